// File: doc/BRIEF.md
# I2C SCL High/Low Period Generator

This block produces the SCL clock of an I2C master from a fast system clock. Each SCL period has two phases. In the low phase the block pulls the line low for a programmed number of cycles. In the released phase it lets the line go and counts a programmed number of cycles before it pulls the line low again. Three pairs of cycle counts are held, one pair for each of standard, fast and high-speed operation. The speed code that is present when the generator is enabled selects the pair that is used. If the build leaves out high-speed support, a request for high speed runs on the fast-mode pair.

The released phase is measured from the moment the synchronised copy of the bus shows SCL high. A slave can therefore stretch the clock by holding SCL low. The stretch lengthens the period but does not shorten the high time. The input synchroniser and the count of the high phase together give a high time of HCNT+3 cycles. The block does not generate START or STOP conditions and does not shift data.

The control state machine has four states:
- OFF: SCL is released and the counters are cleared.
- DRIVE_LOW: SCL is pulled low.
- AWAIT_HIGH: SCL is released and the block waits for the synchronised SCL to read high.
- COUNT_HIGH: the released phase is being counted.

Its transitions are:
- enable: OFF to DRIVE_LOW.
- low done: DRIVE_LOW to AWAIT_HIGH.
- bus seen high: AWAIT_HIGH to COUNT_HIGH.
- high done: COUNT_HIGH to DRIVE_LOW.
- disable: any state to OFF.

Top module: `scl_period_gen`

## Requirements
- R1: After reset, and while `en` is low, `scl_oe` is 0, meaning SCL is released. Deasserting `en` in any phase makes `scl_oe` 0 from the cycle after `en` is sampled low.
- R2: Each low phase drives `scl_oe`=1 for exactly LCNT+1 clock cycles. An LCNT of 0 is handled as 1.
- R3: With no stretching, SCL reads high for exactly HCNT+3 cycles between two low phases. An HCNT of 0 is handled as 1.
- R4: While a slave holds SCL low after the block releases it, `scl_oe` stays 0. The HCNT+3 high time is counted from the cycle in which SCL reads high.
- R5: The `speed_sel` encoding is: 0 or 1 selects standard mode, 2 selects fast mode, and 3 selects high-speed mode.
- R6: When the parameter `HS_EN`=0, `speed_sel`=3 uses the fast-mode count pair.
- R7: The configuration address map is: 0 is standard HCNT, 1 is standard LCNT, 2 is fast HCNT, 3 is fast LCNT, 4 is high-speed HCNT, and 5 is high-speed LCNT. A write with `cfg_we`=1 takes effect only while `en` is 0. Writes made while `en` is 1 are ignored.
- R8: `speed_sel` is captured while the block is off. Changing it while the block is enabled has no effect until the next enable.
- R9: After a disable, the next enable starts a full low phase. Nothing of the interrupted period carries over.
- R10: The first phase after enable is a low phase. `scl_oe` rises in the cycle after `en` is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable |
| speed_sel | input | 2 | Speed code: 0/1 standard, 2 fast, 3 high speed |
| cfg_we | input | 1 | Count register write strobe |
| cfg_addr | input | 3 | Count register select |
| cfg_wdata | input | CNT_W | Count value to write |
| scl_in | input | 1 | SCL level as seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |

## Verification
The bench builds two copies of the block with `CNT_W`=16 and `SYNC_STAGES`=2.

The first copy uses `HS_EN`=1. It covers all three count pairs, the zero-count floors, clock stretching by a modelled slave, writes that are locked out while enabled, and a speed change made mid-run.

The second copy uses `HS_EN`=0. It is the only way to reach the fallback of a high-speed request to the fast-mode pair.

// File: rtl/scl_period_pkg.sv
package scl_period_pkg;

    typedef enum logic [1:0] {
        MODE_STD  = 2'd0,
        MODE_FAST = 2'd1,
        MODE_HS   = 2'd2
    } scl_mode_e;

    typedef enum logic [1:0] {
        PH_OFF        = 2'd0,
        PH_DRIVE_LOW  = 2'd1,
        PH_AWAIT_HIGH = 2'd2,
        PH_COUNT_HIGH = 2'd3
    } scl_phase_e;

    function automatic scl_mode_e decode_speed(input logic [1:0] code);
        case (code)
            2'd2:    return MODE_FAST;
            2'd3:    return MODE_HS;
            default: return MODE_STD;
        endcase
    endfunction

endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw_i,
    output logic scl_hi_o
);
    logic [STAGES-1:0] shreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg_q <= '1;
        else        shreg_q <= {shreg_q[STAGES-2:0], scl_raw_i};
    end

    assign scl_hi_o = shreg_q[STAGES-1];
endmodule

// File: rtl/scl_cnt_bank.sv
module scl_cnt_bank
    import scl_period_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter bit HS_EN    = 1'b1,
    parameter int RST_HCNT = 6,
    parameter int RST_LCNT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             we_i,
    input  logic [2:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  scl_mode_e        mode_i,
    output logic [CNT_W-1:0] hcnt_o,
    output logic [CNT_W-1:0] lcnt_o
);
    localparam int NUM_MODES = HS_EN ? 3 : 2;
    localparam int HS_IDX    = HS_EN ? 2 : 1;

    logic [NUM_MODES-1:0][CNT_W-1:0] h_q;
    logic [NUM_MODES-1:0][CNT_W-1:0] l_q;
    logic [1:0]                      idx;

    // Writes land only while the generator is off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int m = 0; m < NUM_MODES; m++) begin
                h_q[m] <= CNT_W'(RST_HCNT);
                l_q[m] <= CNT_W'(RST_LCNT);
            end
        end else if (we_i && !en_i) begin
            for (int m = 0; m < NUM_MODES; m++) begin
                if (addr_i == 3'(2 * m))     h_q[m] <= wdata_i;
                if (addr_i == 3'(2 * m + 1)) l_q[m] <= wdata_i;
            end
        end
    end

    always_comb begin
        unique case (mode_i)
            MODE_STD:  idx = 2'd0;
            MODE_FAST: idx = 2'd1;
            default:   idx = 2'(HS_IDX);
        endcase
    end

    assign hcnt_o = h_q[idx];
    assign lcnt_o = l_q[idx];

    // R7: configuration frozen while enabled
    p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> ($stable(h_q) && $stable(l_q)));

    generate
        if (!HS_EN) begin : g_no_hs
            // R6: high-speed request served by fast pair
            p_hs_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == MODE_HS) |-> (hcnt_o == h_q[1] && lcnt_o == l_q[1]));
        end
    endgenerate
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_period_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [1:0]       speed_i,
    input  logic             bus_hi_i,
    input  logic [CNT_W-1:0] hcnt_i,
    input  logic [CNT_W-1:0] lcnt_i,
    output scl_mode_e        mode_o,
    output logic             scl_oe_o
);
    scl_phase_e       state_q, state_d;
    scl_mode_e        mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lcnt_eff, hcnt_eff;

    assign lcnt_eff = (lcnt_i == '0) ? CNT_W'(1) : lcnt_i;
    assign hcnt_eff = (hcnt_i == '0) ? CNT_W'(1) : hcnt_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_OFF;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = PH_OFF;
        end else begin
            unique case (state_q)
                PH_OFF:        state_d = PH_DRIVE_LOW;
                PH_DRIVE_LOW:  if (cnt_q >= lcnt_eff) state_d = PH_AWAIT_HIGH;
                PH_AWAIT_HIGH: if (bus_hi_i)          state_d = PH_COUNT_HIGH;
                PH_COUNT_HIGH: if (cnt_q >= hcnt_eff) state_d = PH_DRIVE_LOW;
            endcase
        end
    end

    // Phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d == PH_OFF) begin
            cnt_q <= '0;
        end else if (state_d != state_q) begin
            cnt_q <= (state_d == PH_COUNT_HIGH) ? CNT_W'(1) : '0;
        end else if (state_q == PH_DRIVE_LOW || state_q == PH_COUNT_HIGH) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Speed captured while off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                mode_q <= MODE_STD;
        else if (state_q == PH_OFF) mode_q <= decode_speed(speed_i);
    end

    // Outputs
    always_comb begin
        mode_o   = mode_q;
        scl_oe_o = 1'b0;
        unique case (state_q)
            PH_DRIVE_LOW: scl_oe_o = 1'b1;
            default:      scl_oe_o = 1'b0;
        endcase
    end

    // R1: disable releases SCL on the next cycle
    p_release_on_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !scl_oe_o);

    // R2: low counter never runs past its limit
    p_low_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_DRIVE_LOW) |-> (cnt_q <= lcnt_eff));

    // R4: high counting begins only after SCL was seen high
    p_high_after_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_COUNT_HIGH && $past(state_q) == PH_AWAIT_HIGH) |-> $past(bus_hi_i));

    // R8: mode stays fixed while running
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_OFF && $past(state_q) != PH_OFF) |-> $stable(mode_q));

    // R10: enable from off always starts with a low phase
    p_first_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_OFF && en_i) |=> scl_oe_o);
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
    import scl_period_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter bit HS_EN       = 1'b1,
    parameter int SYNC_STAGES = 2,
    parameter int RST_HCNT    = 6,
    parameter int RST_LCNT    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       speed_sel,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             scl_in,
    output logic             scl_oe
);
    logic             bus_hi;
    scl_mode_e        act_mode;
    logic [CNT_W-1:0] sel_hcnt, sel_lcnt;

    scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw_i (scl_in),
        .scl_hi_o  (bus_hi)
    );

    scl_cnt_bank #(
        .CNT_W    (CNT_W),
        .HS_EN    (HS_EN),
        .RST_HCNT (RST_HCNT),
        .RST_LCNT (RST_LCNT)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .mode_i  (act_mode),
        .hcnt_o  (sel_hcnt),
        .lcnt_o  (sel_lcnt)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .speed_i  (speed_sel),
        .bus_hi_i (bus_hi),
        .hcnt_i   (sel_hcnt),
        .lcnt_i   (sel_lcnt),
        .mode_o   (act_mode),
        .scl_oe_o (scl_oe)
    );
endmodule

// File: tb/scl_period_gen_bench.sv
module scl_period_gen_bench;
    localparam int CW = 16;

    typedef struct {
        int    lo;
        int    hi;
        int    st;
        string req;
    } period_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en1 = 1'b0, en2 = 1'b0;
    logic [1:0]    speed = 2'd1;
    logic          we = 1'b0;
    logic [2:0]    addr = '0;
    logic [CW-1:0] wdata = '0;
    logic          oe1, oe2, bus1, bus2;
    int            stretch_n = 0;
    int            st_cnt = 0;
    bit            use_nohs = 1'b0;
    int            n_chk = 0, n_fail = 0;
    bit            done = 1'b0;
    period_t       exp_q[$];

    always #5 clk = ~clk;

    scl_period_gen #(.CNT_W(CW), .HS_EN(1'b1)) u_scl_period_gen (
        .clk(clk), .rst_n(rst_n), .en(en1), .speed_sel(speed),
        .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
        .scl_in(bus1), .scl_oe(oe1));

    scl_period_gen #(.CNT_W(CW), .HS_EN(1'b0)) u_scl_period_gen_nohs (
        .clk(clk), .rst_n(rst_n), .en(en2), .speed_sel(speed),
        .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
        .scl_in(bus2), .scl_oe(oe2));

    // Bus model: a slave holds SCL low for stretch_n cycles after release
    always @(posedge clk) begin
        if (oe1)             st_cnt <= stretch_n;
        else if (st_cnt > 0) st_cnt <= st_cnt - 1;
    end
    assign bus1 = !(oe1 || st_cnt != 0);
    assign bus2 = !oe2;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: measures each complete period and pops the scoreboard
    int lo_c = 0, hi_c = 0, st_c = 0;
    always @(negedge clk) begin
        logic oe, bus, men;
        oe  = use_nohs ? oe2 : oe1;
        bus = use_nohs ? bus2 : bus1;
        men = use_nohs ? en2 : en1;
        if (!rst_n || !men) begin
            lo_c = 0; hi_c = 0; st_c = 0;
        end else if (oe) begin
            if (hi_c > 0 || st_c > 0) begin
                if (exp_q.size() > 0) begin
                    period_t e;
                    e = exp_q.pop_front();
                    chk({e.req, " low"}, lo_c, e.lo);
                    chk({e.req, " high"}, hi_c, e.hi);
                    chk({e.req, " stretch"}, st_c, e.st);
                end
                lo_c = 0; hi_c = 0; st_c = 0;
            end
            lo_c++;
        end else if (lo_c > 0) begin
            if (bus) hi_c++;
            else     st_c++;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input int v);
        tick(); we = 1'b1; addr = a; wdata = CW'(v);
        tick(); we = 1'b0;
    endtask

    task automatic push(input int lo, input int hi, input int st, input string req, input int n);
        for (int i = 0; i < n; i++) begin
            period_t e;
            e.lo = lo; e.hi = hi; e.st = st; e.req = req;
            exp_q.push_back(e);
        end
    endtask

    task automatic drain();
        int k = 0;
        while (exp_q.size() > 0 && k < 5000) begin
            tick(); k++;
        end
        if (exp_q.size() > 0) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog %0d periods missing, expected 0", exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic run1(input int lo, input int hi, input int st, input string req, input int n);
        stretch_n = st;
        push(lo, hi, st, req, n);
        tick(); en1 = 1'b1;
        drain();
        en1 = 1'b0;
        repeat (3) tick();
        stretch_n = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset release", int'(oe1), 0);

        // standard 4/5, fast 2/3, high speed 1/1
        wr(3'd0, 4); wr(3'd1, 5);
        wr(3'd2, 2); wr(3'd3, 3);
        wr(3'd4, 1); wr(3'd5, 1);

        // R10: first low phase right after enable
        speed = 2'd1;
        push(6, 7, 0, "R2 R3 std", 2);
        tick(); en1 = 1'b1;
        @(negedge clk);
        chk("R10 before edge", int'(oe1), 0);
        @(negedge clk);
        chk("R10 first low", int'(oe1), 1);
        drain();
        tick(); en1 = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R1 disable release", int'(oe1), 0);
        repeat (2) tick();

        run1(6, 7, 3, "R4 stretch3", 2);
        run1(6, 7, 9, "R4 stretch9", 1);

        speed = 2'd2; run1(4, 5, 0, "R5 fast", 2);
        speed = 2'd3; run1(2, 4, 0, "R5 hs", 2);
        speed = 2'd0; run1(6, 7, 0, "R5 code0 std", 1);

        // zero counts behave as one
        wr(3'd0, 0); wr(3'd1, 0);
        run1(2, 4, 0, "R2 R3 zero", 2);
        wr(3'd0, 4); wr(3'd1, 5);

        // R7: writes while enabled are ignored
        speed = 2'd1;
        push(6, 7, 0, "R7 locked", 2);
        tick(); en1 = 1'b1;
        wr(3'd0, 9); wr(3'd1, 9);
        drain();
        en1 = 1'b0; repeat (3) tick();
        run1(6, 7, 0, "R7 after reenable", 1);

        // R8: speed change while running has no effect
        push(6, 7, 0, "R8 held", 3);
        tick(); en1 = 1'b1;
        repeat (2) tick();
        speed = 2'd2;
        drain();
        en1 = 1'b0; repeat (3) tick();
        speed = 2'd1;

        // R9: disable in the middle of a low phase, then full restart
        tick(); en1 = 1'b1;
        repeat (8) tick();
        while (!oe1) tick();
        en1 = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 released mid low", int'(oe1), 0);
        repeat (2) tick();
        run1(6, 7, 0, "R9 restart", 1);

        // R6: no high-speed build falls back to fast counts
        wr(3'd2, 3); wr(3'd3, 2);
        use_nohs = 1'b1;
        speed = 2'd3;
        push(3, 6, 0, "R6 fallback", 2);
        tick(); en2 = 1'b1;
        drain();
        en2 = 1'b0; repeat (3) tick();
        speed = 2'd2;
        push(3, 6, 0, "R6 fast ref", 1);
        tick(); en2 = 1'b1;
        drain();
        en2 = 1'b0; repeat (3) tick();

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule